// File: doc/BRIEF.md
# JTAG Command-Stream Scan Engine

This block is a JTAG master driven by a host through a small register bus. The host does not toggle pins. It writes a stream of command bytes into a write FIFO, using single-, double- or quad-byte writes. The engine takes bytes out of that FIFO one at a time and decodes each one as an instruction. A TMS instruction walks the target's TAP state machine. A TDI/TDO instruction shifts a payload of up to 128 bits into the target and can capture the bits the target returns into a read FIFO of 32-bit words.

A one-hot enable register routes the single internal JTAG engine to one of up to eight ports. The status word tells the host when the engine is idle and how full the write FIFO is. Through the same status address the host can hold the target's test reset active. TCK runs only while a bit is being shifted. Each bit has a low phase, during which TMS and TDI are set up, and a high phase, at whose start TDO is sampled.

The control state machine has seven states. `E_IDLE` fetches an instruction byte. `E_DECODE` goes to `E_TMS` for a TMS instruction with a marker, to `E_LEN_LO` for a TDI/TDO instruction with a payload, and back to `E_IDLE` otherwise. `E_LEN_LO` then `E_LEN_HI` consume the length field. `E_LOAD` fetches a payload byte. `E_SHIFT` returns to `E_LOAD` after the eighth bit of a byte and to `E_IDLE` after the last payload bit. `E_TMS` returns to `E_IDLE` after its last TMS bit. The per-bit clock runs `B_IDLE` → `B_LOW` → `B_HIGH` → `B_IDLE`.

Top module: `jtag_scan_engine`

## Requirements
- R1: After reset, the status word (address 0) reads 0, all TCK, TMS and TDI outputs are low, all test-reset outputs are high, and the read FIFO is empty.
- R2: A double-byte write (address 3) or a quad-byte write (address 4) places its bytes in the write FIFO least significant byte first. A single-byte write (address 2) places the low byte.
- R3: Bit 7 of an instruction byte selects the operation: 0 is TMS, 1 is TDI/TDO. A TMS byte whose bits 5:0 are zero shifts nothing. A TDI/TDO byte with bit 4 clear shifts nothing.
- R4: For a TMS instruction, let N be the position of the highest set bit of bits 5:0. The engine clocks out N TMS bits, namely bits N-1:0 of the argument, LSB first. For example, 0x3F gives five ones and 0x12 gives 0,1,0,0.
- R5: A TDI/TDO instruction with bit 4 set is followed by two length bytes (low byte first). The engine shifts length+1 payload bits onto TDI, LSB first within each byte, taking the bytes in FIFO order.
- R6: During a payload, TMS is low on every bit except the last, where it is high.
- R7: When bit 2 of a TDI/TDO instruction is set, each TDO bit is packed LSB first into 32-bit words, and a final partial word is zero-padded. A read of address 4 returns the oldest word and removes it. The read-FIFO word count is in status bits 3:0. With bit 2 clear, nothing is captured.
- R8: TCK is high for exactly TCK_HALF system clocks per bit. TMS and TDI do not change while TCK is high.
- R9: Address 1 holds the port enable. A write with more than one bit set is ignored. Only the enabled port's TCK toggles, and the other ports stay idle.
- R10: Writing a value with bit 1 set to address 0 drives the enabled port's test-reset output low. Writing 0 releases it.
- R11: Status bit 31 is high while the engine is working. Bits 30:28 give the write-FIFO occupancy, saturating at 7. The whole word is zero only when the engine is idle and the FIFO is empty.
- R12: A write to a FIFO port that has fewer free entries than bytes written is dropped entirely.
- R13: Only bits 6:0 of the low length byte count. The high length byte and bit 7 of the low byte are ignored, so no payload exceeds 128 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the read FIFO at address 4) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| jtag_tck | output | NPORTS | Test clock per port |
| jtag_tms | output | NPORTS | Test mode select per port |
| jtag_tdi | output | NPORTS | Test data to target per port |
| jtag_tdo | input | NPORTS | Test data from target per port |
| jtag_ntrst | output | NPORTS | Active-low test reset per port |

## Verification
A bus write lands at the next clock edge. The status count and the enable and test-reset outputs therefore change one cycle after the write. Each shifted bit then takes 2·TCK_HALF+1 clocks, and a payload byte is fetched only after the previous byte's eighth bit. The bench does not predict absolute cycles for shifted bits. It records TMS and TDI at every rising TCK of the enabled port, feeds TDO from a known pattern that advances at each rising edge, and polls the status word until it reads zero before it compares the shift logs or pops the captured words. Status occupancy is read at a point where the pending byte cannot yet have been consumed: while the current byte is still shifting, which lasts tens of clocks.

// File: rtl/jse_pkg.sv
package jse_pkg;
    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_EN   = 3'd1;
    localparam logic [2:0] A_WB1  = 3'd2;
    localparam logic [2:0] A_WB2  = 3'd3;
    localparam logic [2:0] A_WB4  = 3'd4;

    typedef enum logic [2:0] {
        E_IDLE, E_DECODE, E_LEN_LO, E_LEN_HI, E_LOAD, E_SHIFT, E_TMS
    } eng_state_t;

    typedef enum logic [1:0] {
        B_IDLE, B_LOW, B_HIGH
    } bit_state_t;
endpackage

// File: rtl/jse_wfifo.sv
module jse_wfifo #(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   push_n,
    input  logic [31:0]                  push_data,
    input  logic                         pop,
    output logic [7:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, pop_ok;
    logic [CW-1:0] take;

    always_comb begin
        do_push = (push_n != 3'd0) && (CW'(push_n) <= CW'(DEPTH) - count);
        take    = do_push ? CW'(push_n) : '0;
        pop_ok  = pop && (count != '0);
        head    = mem[rp];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(push_n);
            if (pop_ok)  rp <= rp + AW'(1);
            count <= count + take - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < 4; g++) begin
            if (do_push && (g < int'(push_n)))
                mem[wp + AW'(g)] <= push_data[8*g +: 8];
        end
    end
endmodule

// File: rtl/jse_rfifo.sv
module jse_rfifo #(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [31:0]                  din,
    input  logic                         pop,
    output logic [31:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [31:0]   mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    always_comb begin
        push_ok = push && (count != CW'(DEPTH));
        pop_ok  = pop && (count != '0);
        head    = (count != '0) ? mem[rp] : 32'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end
endmodule

// File: rtl/jse_bitclk.sv
module jse_bitclk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic tms_in,
    input  logic tdi_in,
    input  logic tdo,
    output logic tck,
    output logic tms,
    output logic tdi,
    output logic tdo_q,
    output logic done
);
    import jse_pkg::*;
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    bit_state_t    bst;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(HALF-1));
    assign tck  = (bst == B_HIGH);
    assign done = (bst == B_HIGH) && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bst <= B_IDLE;
            cnt <= '0;
        end else begin
            unique case (bst)
                B_IDLE: if (go) begin bst <= B_LOW; cnt <= '0; end
                B_LOW:  if (last) begin bst <= B_HIGH; cnt <= '0; end
                        else cnt <= cnt + CW'(1);
                B_HIGH: if (last) begin bst <= B_IDLE; cnt <= '0; end
                        else cnt <= cnt + CW'(1);
                default: bst <= B_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tms   <= 1'b0;
            tdi   <= 1'b0;
            tdo_q <= 1'b0;
        end else begin
            if (bst == B_IDLE && go) begin
                tms <= tms_in;
                tdi <= tdi_in;
            end
            if (bst == B_LOW && last) tdo_q <= tdo;
        end
    end
endmodule

// File: rtl/jse_engine.sv
module jse_engine (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  head,
    input  logic        empty,
    output logic        pop,
    output logic        bit_go,
    output logic        bit_tms,
    output logic        bit_tdi,
    input  logic        bit_done,
    input  logic        bit_tdo,
    output logic        rf_push,
    output logic [31:0] rf_data,
    output logic        busy
);
    import jse_pkg::*;

    eng_state_t  state;
    logic        op_q;
    logic [5:0]  arg_q;
    logic [7:0]  remain;
    logic [5:0]  tms_sh;
    logic [2:0]  tms_n;
    logic [7:0]  byte_q;
    logic [2:0]  bidx;
    logic        cap;
    logic [31:0] word;
    logic [4:0]  wbit;

    function automatic logic [2:0] top_bit(input logic [5:0] a);
        logic [2:0] n;
        n = 3'd0;
        for (int i = 0; i < 6; i++) if (a[i]) n = 3'(i);
        return n;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= E_IDLE;  op_q <= 1'b0;  arg_q <= '0;  remain <= '0;
            tms_sh <= '0;  tms_n <= '0;  byte_q <= '0;  bidx <= '0;
            cap <= 1'b0;  word <= '0;  wbit <= '0;
        end else begin
            unique case (state)
                E_IDLE: if (!empty) begin
                    op_q  <= head[7];
                    arg_q <= head[5:0];
                    state <= E_DECODE;
                end
                E_DECODE: begin
                    if (!op_q) begin
                        tms_sh <= arg_q;
                        tms_n  <= top_bit(arg_q);
                        state  <= (top_bit(arg_q) != 3'd0) ? E_TMS : E_IDLE;
                    end else if (arg_q[4]) begin
                        cap   <= arg_q[2];
                        word  <= '0;
                        wbit  <= '0;
                        state <= E_LEN_LO;
                    end else begin
                        state <= E_IDLE;
                    end
                end
                E_LEN_LO: if (!empty) begin
                    remain <= {1'b0, head[6:0]} + 8'd1;
                    state  <= E_LEN_HI;
                end
                E_LEN_HI: if (!empty) state <= E_LOAD;
                E_LOAD: if (!empty) begin
                    byte_q <= head;
                    bidx   <= '0;
                    state  <= E_SHIFT;
                end
                E_SHIFT: if (bit_done) begin
                    remain <= remain - 8'd1;
                    if (cap) begin
                        word <= rf_push ? '0 : rf_data;
                        wbit <= rf_push ? '0 : wbit + 5'd1;
                    end
                    if (remain == 8'd1)    state <= E_IDLE;
                    else if (bidx == 3'd7) state <= E_LOAD;
                    else                   bidx  <= bidx + 3'd1;
                end
                E_TMS: if (bit_done) begin
                    tms_sh <= tms_sh >> 1;
                    tms_n  <= tms_n - 3'd1;
                    if (tms_n == 3'd1) state <= E_IDLE;
                end
                default: state <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        pop     = (state == E_IDLE || state == E_LEN_LO || state == E_LEN_HI ||
                   state == E_LOAD) && !empty;
        bit_go  = (state == E_SHIFT) || (state == E_TMS);
        bit_tms = (state == E_TMS) ? tms_sh[0] : (remain == 8'd1);
        bit_tdi = (state == E_SHIFT) ? byte_q[bidx] : 1'b0;
        rf_data = word | (32'(bit_tdo) << wbit);
        rf_push = (state == E_SHIFT) && bit_done && cap &&
                  ((wbit == 5'd31) || (remain == 8'd1));
        busy    = (state != E_IDLE);
    end
endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine #(
    parameter int NPORTS   = 8,
    parameter int WF_DEPTH = 8,
    parameter int RF_DEPTH = 4,
    parameter int TCK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NPORTS-1:0] jtag_tck,
    output logic [NPORTS-1:0] jtag_tms,
    output logic [NPORTS-1:0] jtag_tdi,
    input  logic [NPORTS-1:0] jtag_tdo,
    output logic [NPORTS-1:0] jtag_ntrst
);
    import jse_pkg::*;
    localparam int WCW = $clog2(WF_DEPTH+1);
    localparam int RCW = $clog2(RF_DEPTH+1);

    logic [NPORTS-1:0] en_q;
    logic              trst_q;
    logic [2:0]        push_n;
    logic [7:0]        wf_head;
    logic [WCW-1:0]    wf_cnt;
    logic [31:0]       rf_head, rf_data;
    logic [RCW-1:0]    rf_cnt;
    logic              wf_pop, rf_push, eng_busy;
    logic              go, b_tms, b_tdi, b_done, b_tdo;
    logic              tck_i, tms_i, tdi_i, tdo_sel;
    logic [2:0]        occ;

    always_comb begin
        push_n = 3'd0;
        if (bus_wr) begin
            unique case (bus_addr)
                A_WB1:   push_n = 3'd1;
                A_WB2:   push_n = 3'd2;
                A_WB4:   push_n = 3'd4;
                default: push_n = 3'd0;
            endcase
        end
        occ     = (wf_cnt > WCW'(7)) ? 3'd7 : wf_cnt[2:0];
        tdo_sel = |(jtag_tdo & en_q);
        unique case (bus_addr)
            A_STAT:  bus_rdata = {eng_busy, occ, 28'd0} | 32'(rf_cnt);
            A_EN:    bus_rdata = 32'(en_q);
            A_WB4:   bus_rdata = rf_head;
            default: bus_rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            trst_q <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_EN && $countones(bus_wdata[NPORTS-1:0]) <= 1)
                en_q <= bus_wdata[NPORTS-1:0];
            if (bus_addr == A_STAT)
                trst_q <= bus_wdata[1];
        end
    end

    jse_wfifo #(.DEPTH(WF_DEPTH)) u_wf (
        .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_data(bus_wdata),
        .pop(wf_pop), .head(wf_head), .count(wf_cnt));

    jse_rfifo #(.DEPTH(RF_DEPTH)) u_rf (
        .clk(clk), .rst_n(rst_n), .push(rf_push), .din(rf_data),
        .pop(bus_rd && bus_addr == A_WB4), .head(rf_head), .count(rf_cnt));

    jse_engine u_eng (
        .clk(clk), .rst_n(rst_n), .head(wf_head), .empty(wf_cnt == '0),
        .pop(wf_pop), .bit_go(go), .bit_tms(b_tms), .bit_tdi(b_tdi),
        .bit_done(b_done), .bit_tdo(b_tdo), .rf_push(rf_push),
        .rf_data(rf_data), .busy(eng_busy));

    jse_bitclk #(.HALF(TCK_HALF)) u_bit (
        .clk(clk), .rst_n(rst_n), .go(go), .tms_in(b_tms), .tdi_in(b_tdi),
        .tdo(tdo_sel), .tck(tck_i), .tms(tms_i), .tdi(tdi_i),
        .tdo_q(b_tdo), .done(b_done));

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign jtag_tck[p]   = en_q[p] & tck_i;
        assign jtag_tms[p]   = en_q[p] & tms_i;
        assign jtag_tdi[p]   = en_q[p] & tdi_i;
        assign jtag_ntrst[p] = ~(en_q[p] & trst_q);
    end
endmodule

// File: rtl/jse_checker.sv
module jse_checker #(
    parameter int NPORTS   = 8,
    parameter int WF_DEPTH = 8,
    parameter int RF_DEPTH = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NPORTS-1:0]             tck,
    input logic [NPORTS-1:0]             tms,
    input logic [NPORTS-1:0]             tdi,
    input logic [NPORTS-1:0]             en,
    input logic                          busy,
    input logic [$clog2(WF_DEPTH+1)-1:0] wf_cnt,
    input logic [$clog2(RF_DEPTH+1)-1:0] rf_cnt
);
    // R8
    tck_high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tck) && $past(|tck)) |-> ($stable(tms) && $stable(tdi)));

    // R9
    en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en));

    // R9
    tck_single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tck));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tck == '0));

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wf_cnt) <= WF_DEPTH);

    // R7
    rd_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rf_cnt) <= RF_DEPTH);
endmodule

bind jtag_scan_engine jse_checker #(
    .NPORTS(NPORTS), .WF_DEPTH(WF_DEPTH), .RF_DEPTH(RF_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tck(jtag_tck), .tms(jtag_tms), .tdi(jtag_tdi),
    .en(en_q), .busy(eng_busy), .wf_cnt(wf_cnt), .rf_cnt(rf_cnt));

// File: tb/tb_jtag_scan_engine.sv
module tb_jtag_scan_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 8;
    localparam int HALF = 2;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [31:0]   bus_wdata = 32'd0, bus_rdata;
    logic [NP-1:0] jtag_tck, jtag_tms, jtag_tdi, jtag_tdo, jtag_ntrst;

    int checks = 0, errors = 0, nlog = 0, bad_port = 0, bad_hi = 0, hi_run = 0;
    logic          tms_log [256];
    logic          tdi_log [256];
    logic [255:0]  tdo_src = '0;
    logic [NP-1:0] exp_en = '0;
    bit            finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_scan_engine #(.NPORTS(NP), .WF_DEPTH(8), .RF_DEPTH(4), .TCK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .jtag_tck(jtag_tck), .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi),
        .jtag_tdo(jtag_tdo), .jtag_ntrst(jtag_ntrst));

    wire tck_any = |jtag_tck;
    assign jtag_tdo = {NP{tdo_src[nlog % 256]}};

    always @(posedge tck_any) begin
        if (nlog < 256) begin
            tms_log[nlog] = |(jtag_tms & exp_en);
            tdi_log[nlog] = |(jtag_tdi & exp_en);
        end
        if (jtag_tck != exp_en) bad_port++;
        nlog++;
    end

    always @(negedge clk) begin
        if (tck_any) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run != HALF) bad_hi++;
            hi_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input bit pop, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = pop;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        for (int k = 0; k < 5000; k++) begin
            bus_read(3'd0, 0, st);
            if (st[31:28] == 4'd0) break;
        end
    endtask

    task automatic wait_room(input int lim);
        logic [31:0] st;
        for (int k = 0; k < 5000; k++) begin
            bus_read(3'd0, 0, st);
            if (int'(st[30:28]) <= lim) break;
        end
    endtask

    function automatic logic [31:0] tms_word(input int n);
        logic [31:0] v = '0;
        for (int i = 0; i < n && i < 32; i++) v[i] = tms_log[i];
        return v;
    endfunction

    function automatic logic [31:0] exp_word(input int w, input int len);
        logic [31:0] v = '0;
        for (int b = 0; b < 32; b++) if (w*32 + b < len) v[b] = tdo_src[w*32 + b];
        return v;
    endfunction

    task automatic run_payload(input int len, input logic [127:0] d, input bit cap);
        logic [159:0] dd = {32'd0, d};
        logic [31:0]  st, w;
        int nb = (len + 7) / 8, i = 0, bad_tdi = 0, bad_tms = 0;
        for (int k = 0; k < 8; k++) tdo_src[32*k +: 32] = $urandom;
        nlog = 0;
        bus_write(3'd2, cap ? 32'h94 : 32'h90);
        bus_write(3'd3, 32'(len - 1));
        while (i < nb) begin
            if (nb - i >= 4 && ($urandom % 2) == 1) begin
                wait_room(4); bus_write(3'd4, dd[8*i +: 32]); i += 4;
            end else begin
                wait_room(6); bus_write(3'd2, {24'd0, dd[8*i +: 8]}); i++;
            end
        end
        wait_idle();
        for (int b = 0; b < len; b++) begin
            if (tdi_log[b] !== d[b]) bad_tdi++;
            if (tms_log[b] !== (b == len - 1)) bad_tms++;
        end
        chk(nlog == len, "R5 payload bit count", 32'(nlog), 32'(len));
        chk(bad_tdi == 0, "R5 payload TDI bits", 32'(bad_tdi), 0);
        chk(bad_tms == 0, "R6 TMS only on last bit", 32'(bad_tms), 0);
        bus_read(3'd0, 0, st);
        if (cap) begin
            chk(st[3:0] == 4'((len + 31) / 32), "R7 captured word count", st[3:0], (len + 31) / 32);
            for (int k = 0; k < (len + 31) / 32; k++) begin
                bus_read(3'd4, 1, w);
                chk(w == exp_word(k, len), "R7 captured word", w, exp_word(k, len));
            end
        end else begin
            chk(st[3:0] == 4'd0, "R7 no capture without flag", st[3:0], 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] st;
        logic [127:0] d;
        int lens [4] = '{1, 32, 33, 128};
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        #1;
        // R1 reset state
        chk(bus_rdata == 32'd0, "R1 status at reset", bus_rdata, 0);
        chk(jtag_tck == '0 && jtag_tms == '0 && jtag_tdi == '0, "R1 pins low", {jtag_tck, jtag_tms, jtag_tdi}, 0);
        chk(jtag_ntrst == '1, "R1 test reset released", 32'(jtag_ntrst), 32'hFF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 enable register
        bus_write(3'd1, 32'h80); exp_en = 8'h80;
        bus_read(3'd1, 0, st);
        chk(st == 32'h80, "R9 enable write", st, 32'h80);
        bus_write(3'd1, 32'h03);
        bus_read(3'd1, 0, st);
        chk(st == 32'h80, "R9 multi-bit enable ignored", st, 32'h80);

        // R10 test reset
        bus_write(3'd0, 32'h2);
        chk(jtag_ntrst == 8'h7F, "R10 test reset asserted", 32'(jtag_ntrst), 32'h7F);
        bus_write(3'd0, 32'h0);
        chk(jtag_ntrst == 8'hFF, "R10 test reset released", 32'(jtag_ntrst), 32'hFF);

        // R4 TMS leading-one decode
        nlog = 0; bus_write(3'd2, 32'h3F); wait_idle();
        chk(nlog == 5 && tms_word(5) == 32'h1F, "R4 TMS 0x3F", tms_word(nlog), 32'h1F);
        nlog = 0; bus_write(3'd2, 32'h12); wait_idle();
        chk(nlog == 4 && tms_word(4) == 32'h2, "R4 TMS 0x12", tms_word(nlog), 32'h2);

        // R3 no-op encodings
        nlog = 0; bus_write(3'd2, 32'h00); bus_write(3'd2, 32'h80); wait_idle();
        chk(nlog == 0, "R3 empty TMS and no-payload TDI", 32'(nlog), 0);

        // R2 byte order of wide writes
        nlog = 0; bus_write(3'd4, 32'h0000_123F); wait_idle();
        chk(nlog == 9 && tms_word(9) == 32'h05F, "R2 quad write LSB first", tms_word(nlog), 32'h05F);
        nlog = 0; bus_write(3'd3, 32'h0000_3F12); wait_idle();
        chk(nlog == 9 && tms_word(9) == 32'h1F2, "R2 double write LSB first", tms_word(nlog), 32'h1F2);

        // R11 busy and occupancy while a byte shifts
        nlog = 0;
        bus_write(3'd2, 32'h90); bus_write(3'd3, 32'h000F); bus_write(3'd2, 32'hA5);
        repeat (8) @(negedge clk);
        bus_write(3'd2, 32'h3C);
        bus_read(3'd0, 0, st);
        chk(st[31] == 1'b1 && st[30:28] == 3'd1, "R11 busy with one byte queued", st, 32'h9000_0000);
        wait_idle();
        d = '0;
        for (int b = 0; b < 16; b++) d[b] = tdi_log[b];
        chk(nlog == 16 && d[15:0] == 16'h3CA5, "R5 two-byte payload", d[31:0], 32'h3CA5);
        bus_read(3'd0, 0, st);
        chk(st == 32'd0, "R11 status zero when idle", st, 0);

        // R12 full FIFO drops a write, R11 saturation
        nlog = 0;
        for (int k = 0; k < 4; k++) d[32*k +: 32] = $urandom;
        bus_write(3'd2, 32'h90); bus_write(3'd3, 32'h007F); bus_write(3'd2, {24'd0, d[7:0]});
        repeat (10) @(negedge clk);
        bus_write(3'd4, d[39:8]); bus_write(3'd4, d[71:40]);
        bus_read(3'd0, 0, st);
        chk(st[30:28] == 3'd7, "R11 occupancy saturates at 7", st[30:28], 7);
        bus_write(3'd2, 32'hEE);
        for (int b = 9; b < 16; b++) begin
            wait_room(6); bus_write(3'd2, {24'd0, d[8*b +: 8]});
        end
        wait_idle();
        begin
            int bad = 0;
            for (int b = 0; b < 128; b++) if (tdi_log[b] !== d[b]) bad++;
            chk(nlog == 128 && bad == 0, "R12 write to full FIFO dropped", 32'(bad), 0);
        end

        // R13 length high bits ignored
        nlog = 0;
        bus_write(3'd2, 32'h90); bus_write(3'd3, 32'h0583); bus_write(3'd2, 32'h0A);
        wait_idle();
        chk(nlog == 4 && tdi_log[1] && tdi_log[3] && !tdi_log[0] && !tdi_log[2],
            "R13 length bits 6:0 only", 32'(nlog), 4);

        // R5 R6 R7 directed lengths then random
        foreach (lens[k]) begin
            for (int j = 0; j < 4; j++) d[32*j +: 32] = $urandom;
            run_payload(lens[k], d, 1'b1);
        end
        for (int t = 0; t < 6; t++) begin
            for (int j = 0; j < 4; j++) d[32*j +: 32] = $urandom;
            run_payload(1 + int'($urandom % 128), d, ($urandom % 3) != 0);
        end

        // R9 switch to another port
        bus_write(3'd1, 32'h04); exp_en = 8'h04;
        nlog = 0; bus_write(3'd2, 32'h3F); wait_idle();
        chk(nlog == 5, "R9 port 2 clocks", 32'(nlog), 5);
        chk(bad_port == 0, "R9 only enabled port toggles", 32'(bad_port), 0);
        chk(bad_hi == 0, "R8 TCK high width", 32'(bad_hi), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule